// File: doc/BRIEF.md
# Sink Capability Validator

This block runs once the auxiliary channel is up. On a start pulse it asks an abstract burst-read port for the first twelve bytes of the sink's configuration space, starting at offset 0. If an attempt ends in an error, or returns the wrong number of bytes, it tries again, up to a fixed number of attempts. When an attempt succeeds it inspects the revision, maximum link rate and maximum lane-count bytes. If all three are acceptable it publishes them, together with the enhanced-framing capability, for the link-training stage that follows.

Every run ends with a single done pulse and a two-bit result code. A revision the block does not support, a link rate or lane count that is not allowed, and a read that never succeeds each give a different nonzero code. The capability outputs change only on a successful run, so the training stage always sees the last accepted set.

Top module: `sink_caps_validator`

## Requirements
- R1: A start pulse in idle raises `rd_req_o` with `rd_addr_o` = 0 and `rd_len_o` = 12. The request stays high until `rd_resp_i` is seen.
- R2: An attempt succeeds only when `rd_resp_i` arrives with `rd_err_i` = 0 and exactly 12 `rd_vld_i` bytes have been received in that attempt. Any other attempt is retried after `rd_req_o` has been low for one cycle. Bytes from failed attempts are discarded.
- R3: At most 5 attempts are made. If the fifth fails, the run ends with code 3 and the capability outputs keep their previous values.
- R4: Byte 0 (revision) must be 0x10 or 0x11; any other value ends the run with code 1. This check takes priority over the checks in R5 and R8.
- R5: Byte 1 (rate) must be 0x06 or 0x0A; any other value ends the run with code 2.
- R6: For revision 0x11, the lane count is bits 4..0 of byte 2 and `efc_o` is bit 7 of byte 2. Bits 6..5 are ignored.
- R7: For revision 0x10, all eight bits of byte 2 form the lane count, and `efc_o` is 0.
- R8: The lane count must be exactly 1, 2 or 4; any other value ends the run with code 2.
- R9: `done_o` is high for exactly one cycle per run. On success `err_o` = 0 and `rev_o`, `rate_o`, `lanes_o` and `efc_o` are updated in that same cycle. On any error they are left unchanged.
- R10: `start_i` has no effect while a run is in progress: it causes neither an extra run nor an extra done pulse.
- R11: After reset, `done_o`, `rd_req_o`, `err_o` and all capability outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a validation run |
| rd_req_o | output | 1 | Burst read request, held high until the response |
| rd_addr_o | output | ADDR_W | Start offset of the burst (0) |
| rd_len_o | output | LEN_W | Burst length in bytes (12) |
| rd_vld_i | input | 1 | Read data byte valid |
| rd_data_i | input | 8 | Read data byte, in order from the start offset |
| rd_resp_i | input | 1 | End of the attempt |
| rd_err_i | input | 1 | Attempt failed; qualified by rd_resp_i |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 2 | 0 ok, 1 unsupported revision, 2 bad rate or lane count, 3 read failure |
| rev_o | output | 8 | Accepted revision code |
| rate_o | output | 8 | Accepted maximum link rate code |
| lanes_o | output | 3 | Accepted lane count (1, 2 or 4) |
| efc_o | output | 1 | Sink supports enhanced framing |

## Verification
The assertions rely on the read port following a simple protocol. `rd_resp_i` is pulsed only while `rd_req_o` is high, and data bytes arrive only inside a request. `start_i` is a pulse, not a level held across the end of a run. The bench's responder model reacts only to a request that it sees high at a falling edge, and sends its bytes and then the response in the cycles that follow. Failed attempts alternate between an error response and an eleven-byte short burst of random data. The bench raises `start_i` in the middle of a burst only to test R10, and always lowers it before the response.

// File: rtl/scv_pkg.sv
package scv_pkg;
  typedef enum logic [1:0] {
    SCV_OK     = 2'd0,
    SCV_NODEV  = 2'd1,
    SCV_INVAL  = 2'd2,
    SCV_RDFAIL = 2'd3
  } scv_err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_GAP,
    ST_EVAL
  } scv_state_e;

  localparam logic [7:0] REV_V10  = 8'h10;
  localparam logic [7:0] REV_V11  = 8'h11;
  localparam logic [7:0] RATE_LOW = 8'h06;
  localparam logic [7:0] RATE_HI  = 8'h0A;

  typedef struct packed {
    logic [7:0] rev;
    logic [7:0] rate;
    logic [2:0] lanes;
    logic       efc;
  } scv_caps_t;
endpackage

// File: rtl/scv_capture.sv
module scv_capture #(
  parameter int BURST_LEN = 12,
  parameter int KEEP      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 vld_i,
  input  logic [7:0]           data_i,
  output logic [KEEP-1:0][7:0] keep_o,
  output logic                 full_o
);
  localparam int CNT_W = $clog2(BURST_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(BURST_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  // count saturates one past the burst so an over-long burst is rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (vld_i && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < KEEP; g++) begin : g_keep
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   keep_o[g] <= '0;
      else if (vld_i && cnt_q == CNT_W'(g) && !clr_i) keep_o[g] <= data_i;
    end
  end

  assign full_o = (cnt_q == CNT_W'(BURST_LEN));
endmodule

// File: rtl/scv_decode.sv
module scv_decode
  import scv_pkg::*;
(
  input  logic [7:0] rev_i,
  input  logic [7:0] rate_i,
  input  logic [7:0] lane_byte_i,
  output scv_err_e   code_o,
  output scv_caps_t  caps_o
);
  logic       rev_ok, rate_ok, lane_ok, is_v11;
  logic [7:0] lane_raw;

  always_comb begin
    is_v11   = (rev_i == REV_V11);
    rev_ok   = (rev_i == REV_V10) || is_v11;
    rate_ok  = (rate_i == RATE_LOW) || (rate_i == RATE_HI);
    lane_raw = is_v11 ? {3'b000, lane_byte_i[4:0]} : lane_byte_i;
    lane_ok  = (lane_raw == 8'd1) || (lane_raw == 8'd2) || (lane_raw == 8'd4);

    if (!rev_ok)       code_o = SCV_NODEV;
    else if (!rate_ok) code_o = SCV_INVAL;
    else if (!lane_ok) code_o = SCV_INVAL;
    else               code_o = SCV_OK;

    caps_o.rev   = rev_i;
    caps_o.rate  = rate_i;
    caps_o.lanes = lane_raw[2:0];
    caps_o.efc   = is_v11 & lane_byte_i[7];
  end
endmodule

// File: rtl/sink_caps_validator.sv
module sink_caps_validator
  import scv_pkg::*;
#(
  parameter int BURST_LEN = 12,
  parameter int MAX_TRIES = 5,
  parameter int ADDR_W    = 20,
  parameter int BASE_ADDR = 0,
  localparam int LEN_W    = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [LEN_W-1:0]  rd_len_o,
  input  logic              rd_vld_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_resp_i,
  input  logic              rd_err_i,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic [7:0]        rev_o,
  output logic [7:0]        rate_o,
  output logic [2:0]        lanes_o,
  output logic              efc_o
);
  localparam int KEEP  = 3;
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

  scv_state_e          state_q;
  logic [TRY_W-1:0]    tries_q;
  logic                done_q;
  scv_err_e            err_q;
  scv_caps_t           caps_q;

  logic                cap_clr, cap_vld, cap_full;
  logic [KEEP-1:0][7:0] cap_bytes;
  scv_err_e            dec_code;
  scv_caps_t           dec_caps;

  assign cap_clr = (state_q == ST_IDLE && start_i) || (state_q == ST_GAP);
  assign cap_vld = rd_vld_i && (state_q == ST_REQ);

  scv_capture #(
    .BURST_LEN(BURST_LEN),
    .KEEP     (KEEP)
  ) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cap_clr),
    .vld_i  (cap_vld),
    .data_i (rd_data_i),
    .keep_o (cap_bytes),
    .full_o (cap_full)
  );

  scv_decode u_decode (
    .rev_i       (cap_bytes[0]),
    .rate_i      (cap_bytes[1]),
    .lane_byte_i (cap_bytes[2]),
    .code_o      (dec_code),
    .caps_o      (dec_caps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tries_q <= '0;
      done_q  <= 1'b0;
      err_q   <= SCV_OK;
      caps_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_REQ;
          tries_q <= '0;
        end
        ST_REQ: if (rd_resp_i) begin
          if (!rd_err_i && cap_full) begin
            state_q <= ST_EVAL;
          end else if (tries_q == LAST_TRY) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= SCV_RDFAIL;
          end else begin
            tries_q <= tries_q + 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP:  state_q <= ST_REQ;
        ST_EVAL: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          err_q   <= dec_code;
          if (dec_code == SCV_OK) caps_q <= dec_caps;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == ST_REQ);
  assign rd_addr_o = ADDR_W'(BASE_ADDR);
  assign rd_len_o  = LEN_W'(BURST_LEN);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rev_o     = caps_q.rev;
  assign rate_o    = caps_q.rate;
  assign lanes_o   = caps_q.lanes;
  assign efc_o     = caps_q.efc;
endmodule

// File: rtl/sink_caps_validator_chk.sv
module sink_caps_validator_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_req_o,
  input logic       rd_resp_i,
  input logic       rd_err_i,
  input logic       done_o,
  input logic [1:0] err_o,
  input logic [7:0] rev_o,
  input logic [7:0] rate_o,
  input logic [2:0] lanes_o,
  input logic       efc_o
);
  assert_req_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_resp_i |=> rd_req_o);

  assert_retry_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_resp_i && rd_err_i |=> !rd_req_o);

  assert_keep_on_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o != 2'd0 |-> $stable(rev_o) && $stable(rate_o) &&
                                $stable(lanes_o) && $stable(efc_o));

  assert_rate_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o == 2'd0 |-> rate_o == 8'h06 || rate_o == 8'h0A);

  assert_v10_no_efc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o == 2'd0 && rev_o == 8'h10 |-> !efc_o);

  assert_lanes_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o == 2'd0 |-> $onehot0(lanes_o) && lanes_o != 3'd0);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);
endmodule

bind sink_caps_validator sink_caps_validator_chk u_chk (.*);

// File: tb/sink_caps_validator_tb.sv
`timescale 1ns/1ps
module sink_caps_validator_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_req_o;
  logic [19:0] rd_addr_o;
  logic [3:0]  rd_len_o;
  logic        rd_vld_i = 1'b0;
  logic [7:0]  rd_data_i = 8'h00;
  logic        rd_resp_i = 1'b0;
  logic        rd_err_i = 1'b0;
  logic        done_o;
  logic [1:0]  err_o;
  logic [7:0]  rev_o, rate_o;
  logic [2:0]  lanes_o;
  logic        efc_o;

  always #10 clk_i = ~clk_i;

  sink_caps_validator dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit poke_start = 0;
  logic [7:0] cb0, cb1, cb2;
  logic [7:0] e_rev = 0, e_rate = 0;
  logic [2:0] e_lanes = 0;
  logic       e_efc = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_code(logic [7:0] b0, b1, b2);
    logic [7:0] ln;
    if (b0 != 8'h10 && b0 != 8'h11) return 2'd1;
    if (b1 != 8'h06 && b1 != 8'h0A) return 2'd2;
    ln = (b0 == 8'h11) ? (b2 & 8'h1F) : b2;
    if (ln != 8'd1 && ln != 8'd2 && ln != 8'd4) return 2'd2;
    return 2'd0;
  endfunction

  task automatic serve(bit good, int idx);
    int n;
    bit e;
    n = good ? 12 : ((idx % 2 == 0) ? 12 : 11);
    e = good ? 1'b0 : (idx % 2 == 0);
    for (int i = 0; i < n; i++) begin
      rd_vld_i  = 1'b1;
      rd_data_i = !good ? 8'($urandom) :
                  (i == 0) ? cb0 : (i == 1) ? cb1 : (i == 2) ? cb2 : 8'($urandom);
      if (poke_start && i == 1) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    rd_vld_i  = 1'b0;
    rd_resp_i = 1'b1;
    rd_err_i  = e;
    @(negedge clk_i);
    rd_resp_i = 1'b0;
    rd_err_i  = 1'b0;
  endtask

  task automatic run_case(logic [7:0] b0, b1, b2, int nfail, string tag);
    int attempts = 0;
    int guard = 0;
    bit got = 0;
    logic [1:0] ecode;
    cb0 = b0; cb1 = b1; cb2 = b2;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk({tag, " R1 addr"}, 32'(rd_addr_o), 0);
    chk({tag, " R1 len"}, 32'(rd_len_o), 12);
    while (!got && guard < 3000) begin
      guard++;
      if (done_o) got = 1;
      else if (rd_req_o) begin
        attempts++;
        serve(attempts > nfail, attempts);
      end else @(negedge clk_i);
    end
    if (!got) begin
      chk({tag, " R9 done seen"}, 0, 1);
      return;
    end
    ecode = (nfail >= 5) ? 2'd3 : model_code(b0, b1, b2);
    chk({tag, " R2 R3 attempts"}, attempts, (nfail >= 5) ? 5 : nfail + 1);
    chk({tag, " R4 R5 R8 code"}, 32'(err_o), 32'(ecode));
    if (ecode == 2'd0) begin
      e_rev   = b0;
      e_rate  = b1;
      e_lanes = (b0 == 8'h11) ? b2[2:0] : b2[2:0];
      e_efc   = (b0 == 8'h11) ? b2[7] : 1'b0;
    end
    chk({tag, " R9 rev"}, 32'(rev_o), 32'(e_rev));
    chk({tag, " R9 rate"}, 32'(rate_o), 32'(e_rate));
    chk({tag, " R6 R7 lanes"}, 32'(lanes_o), 32'(e_lanes));
    chk({tag, " R6 R7 efc"}, 32'(efc_o), 32'(e_efc));
    @(negedge clk_i);
    chk({tag, " R9 pulse"}, 32'(done_o), 0);
    chk({tag, " R10 no rerun"}, 32'(rd_req_o), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 done", 32'(done_o), 0);
    chk("R11 req", 32'(rd_req_o), 0);
    chk("R11 err", 32'(err_o), 0);
    chk("R11 caps", {rev_o, rate_o, 5'd0, lanes_o, 7'd0, efc_o}, 0);

    run_case(8'h10, 8'h06, 8'h01, 0, "v10 basic");
    run_case(8'h11, 8'h0A, 8'h84, 0, "v11 efc");
    run_case(8'h11, 8'h0A, 8'hE2, 0, "R6 ignore bits");
    run_case(8'h10, 8'h0A, 8'h84, 0, "R7 whole byte");
    run_case(8'h12, 8'h06, 8'h01, 0, "R4 bad rev");
    run_case(8'h12, 8'h07, 8'h03, 0, "R4 priority");
    run_case(8'h11, 8'h08, 8'h01, 0, "R5 bad rate");
    run_case(8'h11, 8'h06, 8'h03, 0, "R8 lane 3");
    run_case(8'h11, 8'h06, 8'h80, 0, "R8 lane 0");
    run_case(8'h10, 8'h06, 8'h02, 4, "R3 last try ok");
    run_case(8'h11, 8'h0A, 8'h01, 5, "R3 exhausted");
    poke_start = 1;
    run_case(8'h10, 8'h0A, 8'h04, 1, "R10 start busy");
    poke_start = 0;

    for (int k = 0; k < 40; k++) begin
      logic [7:0] r0, r1, r2;
      int nf;
      case ($urandom_range(0, 3))
        0: r0 = 8'h10;
        1, 2: r0 = 8'h11;
        default: r0 = 8'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: r1 = 8'h06;
        1, 2: r1 = 8'h0A;
        default: r1 = 8'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: r2 = 8'h01;
        1: r2 = {$urandom_range(0, 7) == 0, 2'($urandom), 5'd2};
        2: r2 = {1'b1, 2'($urandom), 5'd4};
        default: r2 = 8'($urandom);
      endcase
      nf = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 6) : 0;
      run_case(r0, r1, r2, nf, "random");
    end
    finish_run();
  end
endmodule